// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences the status and program-counter changes a processor core makes when it takes an exception and when a handler returns from one. Each cycle it looks at seven exception request lines, the current status word, the current PC, a handler-return request and a direct status-write request. When something is accepted, it produces one registered set of write strobes. The strobes carry the new status word, the save-register write for the target mode, the link-register write for the target mode and the new PC. The register file that holds the banked registers sits outside this block. It applies these strobes and feeds back the current mode's saved status and link value.

On entry, the block copies the current status word into the target mode's save register. It then rewrites the mode field and the mask bits, writes the current PC into the target mode's link register, and jumps to the exception's vector. The vector sits either near address zero or near the top of the address space, chosen by an input. On return, the block restores the status word from the save register and the PC from the link value. The link value is first adjusted by 4 when the handler runs in IRQ mode. Status writes from user mode have no effect.

Top module: `exc_ctrl`

## Requirements
- R1: When several accepted requests are present, exactly one is taken. Priority from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt. The request bit positions in `exc_req_i` are 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ.
- R2: An IRQ request is ignored while status bit 8 is set, and an FIQ request is ignored while status bit 7 is set. A reset request is accepted whatever the mask bits are.
- R3: The new PC on entry is the base plus a per-exception offset. The base is 0 when `hivec_i` is low and 0xFFFF0000 when it is high. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. `vec_high_o` reports the base that was used.
- R4: On entry, the new status word keeps bits 31..9 of the current one. The mode field in bits 4..0 becomes the target mode. The encodings are USR 10000, FIQ 10001, IRQ 10010, SVC 10011, ABT 10111, UND 11011 and SYS 11111. The targets are SVC for reset and software interrupt, UND for undefined, ABT for both aborts, IRQ for IRQ and FIQ for FIQ. Bit 8 is set and bit 6 is cleared. Bit 7 is set for FIQ and reset and otherwise keeps its value.
- R5: On entry, the save-register write carries the unmodified current status word. The link-register write carries the current PC. Both name the target mode.
- R6: A return request restores the status word from `spsr_i` and sets the PC to `lr_i`. In IRQ mode the PC is set to `lr_i` minus 4 instead. A return writes neither the save register nor the link register.
- R7: In USR mode, status writes and returns are ignored. A return in SYS mode is also ignored, since that mode has no save register. A direct status write in any other mode sets the status word to `sr_wdata_i`.
- R8: When several kinds of event arrive together, an exception entry takes precedence over a return, and a return takes precedence over a status write.
- R9: Results appear on the outputs in the cycle after the inputs that caused them. In a cycle with no accepted event, all write strobes are low.
- R10: While `rst_ni` is low, all strobes and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 7 | Exception requests, bit positions per R1 |
| hivec_i | input | 1 | Selects the high vector base |
| ret_i | input | 1 | Handler return request |
| sr_wr_i | input | 1 | Direct status-word write request |
| sr_wdata_i | input | 32 | Data for a direct status write |
| sr_i | input | 32 | Current status word |
| spsr_i | input | 32 | Saved status of the current mode |
| pc_i | input | 32 | Current PC, used as the link value on entry |
| lr_i | input | 32 | Link register of the current mode |
| sr_we_o | output | 1 | Status word write strobe |
| sr_o | output | 32 | New status word |
| spsr_we_o | output | 1 | Save-register write strobe |
| spsr_mode_o | output | 5 | Mode whose save register is written |
| spsr_o | output | 32 | Data for the save register |
| lr_we_o | output | 1 | Link-register write strobe |
| lr_mode_o | output | 5 | Mode whose link register is written |
| lr_o | output | 32 | Data for the link register |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | 32 | New PC |
| vec_high_o | output | 1 | Vector base used on the last entry |

## Verification
Every cycle, the assertions check the following. The arbiter grant is one-hot and only covers raised requests. An entry fires all four strobes together with matching modes, and it leaves a masked and Thumb-cleared status with an aligned vector address. An IRQ entry never follows a set IRQ mask. No write comes from user mode, and no strobe appears without a request in the previous cycle. The exact vector for each exception on both bases, the preserved flag bits, the IRQ return adjustment and the outcome of each priority contest depend on concrete values. Only the bench's directed and random scenarios, compared against its own model, can show those.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int NUM_EXC = 7;
  localparam int MODE_W  = 5;
  localparam int SR_I    = 8;
  localparam int SR_F    = 7;
  localparam int SR_T    = 6;

  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_UND  = 3'd1,
    EXC_SWI  = 3'd2,
    EXC_PABT = 3'd3,
    EXC_DABT = 3'd4,
    EXC_IRQ  = 3'd5,
    EXC_FIQ  = 3'd6
  } exc_e;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // rank 0 is the highest priority
  function automatic exc_e prio_at(input int rank);
    case (rank)
      0:       return EXC_RST;
      1:       return EXC_DABT;
      2:       return EXC_FIQ;
      3:       return EXC_IRQ;
      4:       return EXC_PABT;
      5:       return EXC_UND;
      default: return EXC_SWI;
    endcase
  endfunction

  function automatic mode_e target_mode(input exc_e k);
    case (k)
      EXC_UND:           return M_UND;
      EXC_PABT, EXC_DABT: return M_ABT;
      EXC_IRQ:           return M_IRQ;
      EXC_FIQ:           return M_FIQ;
      default:           return M_SVC;
    endcase
  endfunction

  function automatic logic [4:0] vec_off(input exc_e k);
    case (k)
      EXC_UND:  return 5'h04;
      EXC_SWI:  return 5'h08;
      EXC_PABT: return 5'h0C;
      EXC_DABT: return 5'h10;
      EXC_IRQ:  return 5'h18;
      EXC_FIQ:  return 5'h1C;
      default:  return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXC-1:0] req_i,
  input  logic               irq_off_i,
  input  logic               fiq_off_i,
  output logic               take_o,
  output exc_e               kind_o,
  output logic [NUM_EXC-1:0] grant_o
);
  logic [NUM_EXC-1:0] eff;

  always_comb begin
    eff = req_i;
    eff[EXC_IRQ] = req_i[EXC_IRQ] & ~irq_off_i;
    eff[EXC_FIQ] = req_i[EXC_FIQ] & ~fiq_off_i;
  end

  always_comb begin
    kind_o = EXC_RST;
    for (int r = NUM_EXC - 1; r >= 0; r--) begin
      if (eff[prio_at(r)]) kind_o = prio_at(r);
    end
  end

  assign take_o  = |eff;
  assign grant_o = take_o ? (NUM_EXC'(1) << kind_o) : '0;

  assert_grant_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  assert_reset_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[EXC_RST] |-> grant_o[EXC_RST]);
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  exc_e            kind_i,
  input  logic            hivec_i,
  output logic [XLEN-1:0] addr_o
);
  localparam logic [XLEN-1:0] BASE_HI = XLEN'(HI_BASE);

  logic [XLEN-1:0] base;
  assign base   = hivec_i ? BASE_HI : '0;
  assign addr_o = base | XLEN'(vec_off(kind_i));
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_ctrl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] sr_i,
  input  exc_e            kind_i,
  output logic [XLEN-1:0] sr_o,
  output mode_e           mode_o
);
  always_comb begin
    mode_o = target_mode(kind_i);
    sr_o = sr_i;
    sr_o[MODE_W-1:0] = mode_o;
    sr_o[SR_I] = 1'b1;
    sr_o[SR_T] = 1'b0;
    if (kind_i == EXC_FIQ || kind_i == EXC_RST) sr_o[SR_F] = 1'b1;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000,
  parameter int          IRQ_ADJ = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        exc_req_i,
  input  logic              hivec_i,
  input  logic              ret_i,
  input  logic              sr_wr_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   spsr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   lr_i,
  output logic              sr_we_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              spsr_we_o,
  output logic [4:0]        spsr_mode_o,
  output logic [XLEN-1:0]   spsr_o,
  output logic              lr_we_o,
  output logic [4:0]        lr_mode_o,
  output logic [XLEN-1:0]   lr_o,
  output logic              pc_we_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              vec_high_o
);
  localparam logic [XLEN-1:0] ADJ = XLEN'(IRQ_ADJ);

  logic               take;
  exc_e               kind;
  logic [NUM_EXC-1:0] grant;
  logic [XLEN-1:0]    vec_addr;
  logic [XLEN-1:0]    entry_sr;
  mode_e              entry_mode;
  logic [MODE_W-1:0]  cur_mode;
  logic               priv, ret_ok, wr_ok;
  logic [XLEN-1:0]    ret_pc;

  exc_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (exc_req_i),
    .irq_off_i (sr_i[SR_I]),
    .fiq_off_i (sr_i[SR_F]),
    .take_o    (take),
    .kind_o    (kind),
    .grant_o   (grant)
  );

  exc_vector #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_vec (
    .kind_i  (kind),
    .hivec_i (hivec_i),
    .addr_o  (vec_addr)
  );

  exc_status #(.XLEN(XLEN)) u_sts (
    .sr_i   (sr_i),
    .kind_i (kind),
    .sr_o   (entry_sr),
    .mode_o (entry_mode)
  );

  assign cur_mode = sr_i[MODE_W-1:0];
  assign priv     = cur_mode != M_USR;
  assign ret_ok   = ret_i && priv && (cur_mode != M_SYS);
  assign wr_ok    = sr_wr_i && priv;
  assign ret_pc   = (cur_mode == M_IRQ) ? lr_i - ADJ : lr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_we_o     <= 1'b0;
      sr_o        <= '0;
      spsr_we_o   <= 1'b0;
      spsr_mode_o <= '0;
      spsr_o      <= '0;
      lr_we_o     <= 1'b0;
      lr_mode_o   <= '0;
      lr_o        <= '0;
      pc_we_o     <= 1'b0;
      pc_o        <= '0;
      vec_high_o  <= 1'b0;
    end else begin
      sr_we_o   <= 1'b0;
      spsr_we_o <= 1'b0;
      lr_we_o   <= 1'b0;
      pc_we_o   <= 1'b0;
      if (take) begin
        sr_we_o     <= 1'b1;
        sr_o        <= entry_sr;
        spsr_we_o   <= 1'b1;
        spsr_mode_o <= entry_mode;
        spsr_o      <= sr_i;
        lr_we_o     <= 1'b1;
        lr_mode_o   <= entry_mode;
        lr_o        <= pc_i;
        pc_we_o     <= 1'b1;
        pc_o        <= vec_addr;
        vec_high_o  <= hivec_i;
      end else if (ret_ok) begin
        sr_we_o <= 1'b1;
        sr_o    <= spsr_i;
        pc_we_o <= 1'b1;
        pc_o    <= ret_pc;
      end else if (wr_ok) begin
        sr_we_o <= 1'b1;
        sr_o    <= sr_wdata_i;
      end
    end
  end

  assert_entry_strobes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spsr_we_o |-> (lr_we_o && pc_we_o && sr_we_o && spsr_mode_o == lr_mode_o
                   && spsr_mode_o == sr_o[MODE_W-1:0]));
  assert_entry_masks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spsr_we_o |-> (sr_o[SR_I] && !sr_o[SR_T] && sr_o[XLEN-1:9] == spsr_o[XLEN-1:9]));
  assert_vec_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spsr_we_o |-> (pc_o[1:0] == 2'b00 && pc_o[XLEN-1:5] == (vec_high_o ? XLEN'(HI_BASE) >> 5 : '0)));
  assert_irq_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_we_o && lr_mode_o == M_IRQ) |-> !$past(sr_i[SR_I]));
  assert_user_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_o && !spsr_we_o) |-> $past(sr_i[MODE_W-1:0]) != M_USR);
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(|exc_req_i || ret_i || sr_wr_i) |-> !(sr_we_o || pc_we_o || lr_we_o || spsr_we_o));
  assert_return_no_save_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && !lr_we_o) |-> !spsr_we_o);
endmodule

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  exc_req_i = '0;
  logic        hivec_i = 1'b0, ret_i = 1'b0, sr_wr_i = 1'b0;
  logic [31:0] sr_wdata_i = '0, sr_i = 32'h13, spsr_i = '0, pc_i = '0, lr_i = '0;
  logic        sr_we_o, spsr_we_o, lr_we_o, pc_we_o, vec_high_o;
  logic [31:0] sr_o, spsr_o, lr_o, pc_o;
  logic [4:0]  spsr_mode_o, lr_mode_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  exc_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int pick(input logic [6:0] req, input logic [31:0] sr);
    int ord[7] = '{0, 4, 6, 5, 3, 1, 2};
    logic [6:0] e = req;
    if (sr[8]) e[5] = 1'b0;
    if (sr[7]) e[6] = 1'b0;
    foreach (ord[i]) if (e[ord[i]]) return ord[i];
    return -1;
  endfunction

  function automatic logic [4:0] tmode(input int k);
    case (k)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      5: return 5'b10010;
      6: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] voff(input int k);
    case (k)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  // Apply one cycle of stimulus and compare against the model one edge later
  task automatic step(input logic [6:0] req, input logic hv, input logic rt, input logic wr,
                      input logic [31:0] wd, input logic [31:0] sr, input logic [31:0] sp,
                      input logic [31:0] pc, input logic [31:0] lr);
    int k;
    logic [4:0] m;
    logic [31:0] esr;
    @(negedge clk_i);
    exc_req_i = req; hivec_i = hv; ret_i = rt; sr_wr_i = wr; sr_wdata_i = wd;
    sr_i = sr; spsr_i = sp; pc_i = pc; lr_i = lr;
    @(posedge clk_i); #1;
    k = pick(req, sr);
    m = sr[4:0];
    if (k >= 0) begin
      esr = {sr[31:5], tmode(k)};
      esr[8] = 1'b1; esr[6] = 1'b0;
      if (k == 0 || k == 6) esr[7] = 1'b1;
      chk("R1 strobes", {sr_we_o, spsr_we_o, lr_we_o, pc_we_o}, 4'hF);
      chk("R1 R4 mode", sr_o[4:0], tmode(k));
      chk("R4 status", sr_o, esr);
      chk("R3 vector", pc_o, (hv ? 32'hFFFF0000 : 32'h0) | voff(k));
      chk("R3 base", vec_high_o, hv);
      chk("R5 save", spsr_o, sr);
      chk("R5 link", lr_o, pc);
      chk("R5 modes", {spsr_mode_o, lr_mode_o}, {tmode(k), tmode(k)});
    end else if (rt && m != 5'b10000 && m != 5'b11111) begin
      chk("R6 R8 strobes", {sr_we_o, spsr_we_o, lr_we_o, pc_we_o}, 4'b1001);
      chk("R6 status", sr_o, sp);
      chk("R6 pc", pc_o, (m == 5'b10010) ? lr - 32'd4 : lr);
    end else if (wr && m != 5'b10000) begin
      chk("R7 R8 strobes", {sr_we_o, spsr_we_o, lr_we_o, pc_we_o}, 4'b1000);
      chk("R7 write", sr_o, wd);
    end else begin
      chk("R9 R2 R7 idle", {sr_we_o, spsr_we_o, lr_we_o, pc_we_o}, 4'b0000);
    end
  endtask

  initial begin
    logic [4:0] modes[7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    void'($urandom(32'h5EED1));
    #(CLK_PERIOD * 2 + 1);
    chk("R10 reset strobes", {sr_we_o, spsr_we_o, lr_we_o, pc_we_o, vec_high_o}, 5'b0);
    chk("R10 reset pc", pc_o, 32'h0);
    chk("R10 reset sr", sr_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int k = 0; k < 7; k++) begin
      step(7'(1 << k), 1'b0, 0, 0, 0, 32'hF000_0013, 0, 32'h1000 + k, 0);
      step(7'(1 << k), 1'b1, 0, 0, 0, 32'h0800_0050, 0, 32'h2000 + k, 0);
    end
    step(7'h7F, 0, 0, 0, 0, 32'h13, 0, 32'h40, 0);                 // R1 all raised
    step(7'h7E, 0, 0, 0, 0, 32'h13, 0, 32'h40, 0);                 // R1 data abort wins
    step(7'h6A, 0, 0, 0, 0, 32'h13, 0, 32'h40, 0);                 // R1 FIQ over IRQ
    step(7'h20, 0, 0, 0, 0, 32'h193, 0, 32'h40, 0);                // R2 IRQ masked
    step(7'h40, 0, 0, 0, 0, 32'hD3, 0, 32'h40, 0);                 // R2 FIQ masked
    step(7'h61, 1, 0, 0, 0, 32'h1D3, 0, 32'h40, 0);                // R2 reset under masks
    step(7'h00, 0, 1, 0, 0, 32'h92, 32'h6000_0010, 0, 32'h804);    // R6 IRQ adjust
    step(7'h00, 0, 1, 0, 0, 32'h97, 32'h10, 0, 32'h900);           // R6 abort
    step(7'h00, 0, 1, 1, 32'h1F, 32'h10, 32'h13, 0, 32'h900);      // R7 user
    step(7'h00, 0, 1, 0, 0, 32'h1F, 32'h13, 0, 32'h900);           // R7 system return
    step(7'h00, 0, 0, 1, 32'hA000_001F, 32'h1F, 0, 0, 0);          // R7 system write
    step(7'h04, 0, 1, 1, 32'h1F, 32'h93, 32'h10, 32'h88, 32'h900); // R8 entry first
    step(7'h00, 0, 1, 1, 32'h1F, 32'h93, 32'h10, 32'h88, 32'h900); // R8 return first
    step(7'h00, 0, 0, 0, 0, 32'h13, 0, 0, 0);                      // R9 idle

    for (int n = 0; n < 3000; n++) begin
      logic [6:0] rq;
      logic [31:0] sr;
      for (int b = 0; b < 7; b++) rq[b] = ($urandom % 10) == 0;
      sr = $urandom;
      sr[4:0] = modes[$urandom % 7];
      step(rq, 1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, $urandom,
           sr, $urandom, $urandom, $urandom);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule